// File: doc/BRIEF.md
# Serial Flash Continuous-Read Sequencer

This block is the host side of a streaming read from a serial flash device over a four-wire SPI link. A start request carries a 13-bit page number and a 10-bit column (the byte offset within the page). The sequencer lowers chip select and sends a 32-bit command word. The command word is the continuous-read opcode 0xE8, then one reserved zero bit, then the page, then the column. It then issues 32 clocks whose data is ignored. After that it keeps clocking to pull an unbounded stream of bytes from the device, with no further addressing.

Received bytes go out on a valid/ready byte port. If the consumer is not ready when a byte completes, the sequencer freezes SCK until the byte is taken. A stop request lets the byte in progress complete and then raises chip select. Chip select then stays high for a guard interval before the block will accept another start. The link runs in SPI mode 0. The SCK half period is set at run time in system clock cycles.

Top module: `sflash_stream_reader`

## Requirements
- R1: After reset, and whenever the block is idle, `o_cs_n` is 1, `o_sck` is 0, `o_valid` is 0 and `o_busy` is 0. `o_sck` is never 1 while `o_cs_n` is 1.
- R2: When `i_start` is seen while idle, `o_cs_n` goes low on the next clock edge. The first 32 bits seen on `o_si` at SCK rising edges are 0xE8, then 0, then `i_page[12:0]`, then `i_col[9:0]`. Every field is sent MSB first.
- R3: Exactly 32 SCK rising edges follow the command before the first data bit is sampled. The first byte therefore completes on SCK rising edge 72 of the transaction.
- R4: `i_so` is sampled on SCK rising edges. Each 8 samples form one byte, with the first sample in bit 7. Bytes come out in the order they were received.
- R5: One SCK period lasts 2*(`i_sck_half`+1) clock cycles. `o_si` changes only while `o_sck` is low.
- R6: While `o_valid` is 1 and `i_ready` is 0, `o_valid` and `o_data` hold and `o_sck` does not change. When `i_ready` is 1, `o_valid` lasts one cycle per byte.
- R7: After a stop request, no further byte follows the byte in progress (or the first byte, if the stop came before data). The transaction then ends with `o_cs_n` high.
- R8: Between the end of one transaction and the next falling edge of `o_cs_n`, chip select stays high for at least 4*(`i_sck_half`+1) cycles, which is two SCK periods. A start held high during that time is not acted on early.
- R9: A start request while `o_busy` is 1 is ignored. The command already sent and the data stream are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| i_sck_half | input | 8 | SCK half period minus one, in clock cycles |
| i_start | input | 1 | Begin a streaming read (taken when idle) |
| i_page | input | 13 | Page number for the read |
| i_col | input | 10 | Byte offset within the page |
| i_stop | input | 1 | End the stream after the current byte |
| o_busy | output | 1 | Transaction or guard interval in progress |
| o_cs_n | output | 1 | Flash chip select, active low |
| o_sck | output | 1 | Serial clock, idles low |
| o_si | output | 1 | Serial data to the flash |
| i_so | input | 1 | Serial data from the flash |
| o_data | output | 8 | Received byte |
| o_valid | output | 1 | Received byte valid |
| i_ready | input | 1 | Consumer accepts the byte |

## Verification
Chip select falls one clock after a start is sampled. The first byte becomes valid on the same edge as SCK rising edge 72. The bench's flash model counts SCK edges and drives `i_so` on falling edges, so it checks dummy length and data alignment in edge counts rather than clock cycles. The bench drives every handshake input on the falling clock edge and reads the result at the next falling edge. A byte taken with `i_ready` high must therefore be gone one sample later. SCK period and the chip-select guard interval are timed from the model's recorded edge times and compared with the half-period setting.

// File: rtl/sfr_pkg.sv
`timescale 1ns/1ps
package sfr_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_DUMMY,
        ST_DATA,
        ST_GAP
    } sfr_state_e;

    localparam int GAP_HALVES = 4;
endpackage

// File: rtl/sfr_tick.sv
`timescale 1ns/1ps
module sfr_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             clr,
    input  logic [DIV_W-1:0] half,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        tick  = 1'b0;
        if (clr) begin
            cnt_d = '0;
        end else if (en) begin
            if (cnt_q >= half) begin
                tick  = 1'b1;
                cnt_d = '0;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/sfr_rxbyte.sv
`timescale 1ns/1ps
module sfr_rxbyte #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         sample,
    input  logic         bit_in,
    output logic [W-1:0] data,
    output logic         done,
    output logic         boundary
);
    localparam int CW = $clog2(W);

    typedef struct packed {
        logic [W-2:0] sh;
        logic [CW-1:0] cnt;
    } rx_t;

    rx_t r_d, r_q;

    assign data     = {r_q.sh, bit_in};
    assign done     = sample && (r_q.cnt == CW'(W-1));
    assign boundary = (r_q.cnt == '0);

    always_comb begin
        r_d = r_q;
        if (clr) begin
            r_d.cnt = '0;
        end else if (sample) begin
            r_d.sh  = {r_q.sh[W-3:0], bit_in};
            r_d.cnt = done ? '0 : r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/sflash_stream_reader.sv
`timescale 1ns/1ps
module sflash_stream_reader #(
    parameter int          PAGE_W     = 13,
    parameter int          COL_W      = 10,
    parameter int          ADDR_W     = 24,
    parameter int          DIV_W      = 8,
    parameter int          DUMMY_CLKS = 32,
    parameter logic [7:0]  OPCODE     = 8'hE8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  i_sck_half,
    input  logic              i_start,
    input  logic [PAGE_W-1:0] i_page,
    input  logic [COL_W-1:0]  i_col,
    input  logic              i_stop,
    output logic              o_busy,
    output logic              o_cs_n,
    output logic              o_sck,
    output logic              o_si,
    input  logic              i_so,
    output logic [7:0]        o_data,
    output logic              o_valid,
    input  logic              i_ready
);
    import sfr_pkg::*;

    localparam int CMD_BITS = 8 + ADDR_W;
    localparam int RSV_W    = ADDR_W - PAGE_W - COL_W;
    localparam int CNT_MAX  = (CMD_BITS > DUMMY_CLKS) ? CMD_BITS : DUMMY_CLKS;
    localparam int CNT_W    = $clog2(CNT_MAX);

    typedef struct packed {
        sfr_state_e          st;
        logic                cs_n;
        logic                sck;
        logic [CMD_BITS-1:0] sh;
        logic [CNT_W-1:0]    cnt;
        logic                stop;
        logic [7:0]          dat;
        logic                pend;
    } regs_t;

    regs_t r_d, r_q;

    logic       tick, rise, fall;
    logic       rx_done, rx_boundary;
    logic [7:0] rx_data;

    assign rise = tick && !r_q.sck;
    assign fall = tick &&  r_q.sck;

    sfr_tick #(.DIV_W(DIV_W)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .en   ((r_q.st != ST_IDLE) && !r_q.pend),
        .clr  (r_q.st == ST_IDLE),
        .half (i_sck_half),
        .tick (tick)
    );

    sfr_rxbyte #(.W(8)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (r_q.st != ST_DATA),
        .sample  (rise && (r_q.st == ST_DATA)),
        .bit_in  (i_so),
        .data    (rx_data),
        .done    (rx_done),
        .boundary(rx_boundary)
    );

    always_comb begin
        r_d = r_q;
        if (r_q.pend && i_ready) r_d.pend = 1'b0;
        if (i_stop && (r_q.st inside {ST_CMD, ST_DUMMY, ST_DATA})) r_d.stop = 1'b1;

        unique case (r_q.st)
            ST_IDLE: begin
                if (i_start) begin
                    r_d.st   = ST_CMD;
                    r_d.cs_n = 1'b0;
                    r_d.sck  = 1'b0;
                    r_d.cnt  = '0;
                    r_d.stop = 1'b0;
                    r_d.sh   = {OPCODE, RSV_W'(0), i_page, i_col};
                end
            end
            ST_CMD: begin
                if (rise) begin
                    r_d.sck = 1'b1;
                end else if (fall) begin
                    r_d.sck = 1'b0;
                    r_d.sh  = r_q.sh << 1;
                    if (r_q.cnt == CNT_W'(CMD_BITS-1)) begin
                        r_d.st  = ST_DUMMY;
                        r_d.cnt = '0;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
            end
            ST_DUMMY: begin
                if (rise) begin
                    r_d.sck = 1'b1;
                end else if (fall) begin
                    r_d.sck = 1'b0;
                    if (r_q.cnt == CNT_W'(DUMMY_CLKS-1)) begin
                        r_d.st  = ST_DATA;
                        r_d.cnt = '0;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
            end
            ST_DATA: begin
                if (rise) begin
                    r_d.sck = 1'b1;
                    if (rx_done) begin
                        r_d.pend = 1'b1;
                        r_d.dat  = rx_data;
                    end
                end else if (fall) begin
                    r_d.sck = 1'b0;
                    if (r_q.stop && rx_boundary) begin
                        r_d.st   = ST_GAP;
                        r_d.cs_n = 1'b1;
                        r_d.cnt  = '0;
                    end
                end
            end
            ST_GAP: begin
                if (tick) begin
                    if (r_q.cnt == CNT_W'(GAP_HALVES-1)) r_d.st = ST_IDLE;
                    else                                  r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= ST_IDLE;
            r_q.cs_n <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign o_busy  = (r_q.st != ST_IDLE);
    assign o_cs_n  = r_q.cs_n;
    assign o_sck   = r_q.sck;
    assign o_si    = r_q.sh[CMD_BITS-1];
    assign o_data  = r_q.dat;
    assign o_valid = r_q.pend;
endmodule

// File: rtl/sfr_checker.sv
`timescale 1ns/1ps
module sfr_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       i_start,
    input logic       i_ready,
    input logic       o_busy,
    input logic       o_cs_n,
    input logic       o_sck,
    input logic       o_si,
    input logic [7:0] o_data,
    input logic       o_valid
);
    AST_SCK_LOW_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        o_cs_n |-> !o_sck); // R1

    AST_IDLE_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !o_busy |-> (o_cs_n && !o_valid)); // R1

    AST_CS_FALL_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(o_cs_n) |-> ($past(!o_busy) && $past(i_start))); // R9

    AST_SI_CHANGES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(o_si) |-> !o_sck); // R5

    AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (o_valid && !i_ready) |=> (o_valid && $stable(o_data))); // R6

    AST_SCK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        o_valid |=> $stable(o_sck)); // R6

    AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (o_valid && i_ready) |=> !o_valid); // R6
endmodule

bind sflash_stream_reader sfr_checker u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .i_start(i_start),
    .i_ready(i_ready),
    .o_busy (o_busy),
    .o_cs_n (o_cs_n),
    .o_sck  (o_sck),
    .o_si   (o_si),
    .o_data (o_data),
    .o_valid(o_valid)
);

// File: tb/sflash_stream_reader_tb_top.sv
`timescale 1ns/1ps
module sflash_stream_reader_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  i_sck_half = 8'd0;
    logic        i_start = 1'b0;
    logic [12:0] i_page = '0;
    logic [9:0]  i_col = '0;
    logic        i_stop = 1'b0;
    logic        o_busy, o_cs_n, o_sck, o_si;
    logic        i_so = 1'b0;
    logic [7:0]  o_data;
    logic        o_valid;
    logic        i_ready = 1'b0;

    always #2.5 clk = ~clk;

    sflash_stream_reader dut_i (
        .clk(clk), .rst_n(rst_n), .i_sck_half(i_sck_half), .i_start(i_start),
        .i_page(i_page), .i_col(i_col), .i_stop(i_stop), .o_busy(o_busy),
        .o_cs_n(o_cs_n), .o_sck(o_sck), .o_si(o_si), .i_so(i_so),
        .o_data(o_data), .o_valid(o_valid), .i_ready(i_ready)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    task automatic chk(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(logic [12:0] p, logic [9:0] c, int k);
        return 8'(c) + 8'(37 * k) ^ p[7:0] ^ 8'(k << 4);
    endfunction

    // flash model
    int          rise_cnt = 0;
    logic [31:0] cmd_cap = '0;
    logic [12:0] m_page = '0;
    logic [9:0]  m_col = '0;
    realtime     t_r5, t_r6, t_csr, t_csf;
    int          sck_cs_bad = 0;

    always @(negedge o_cs_n) begin
        t_csf    = $realtime;
        rise_cnt = 0;
        cmd_cap  = '0;
        i_so     = 1'b0;
    end
    always @(posedge o_cs_n) t_csr = $realtime;

    always @(posedge o_sck) begin
        if (!o_cs_n) begin
            rise_cnt++;
            if (rise_cnt <= 32) cmd_cap = {cmd_cap[30:0], o_si};
            if (rise_cnt == 5) t_r5 = $realtime;
            if (rise_cnt == 6) t_r6 = $realtime;
        end
    end

    always @(negedge o_sck) begin
        if (!o_cs_n && rise_cnt >= 64) begin
            int b;
            logic [7:0] v;
            b    = rise_cnt - 64;
            v    = pat(m_page, m_col, b / 8);
            i_so = v[7 - (b % 8)];
        end
    end

    always @(negedge clk) if (rst_n && o_cs_n && o_sck) sck_cs_bad++;

    typedef struct packed {
        logic [12:0] page;
        logic [9:0]  col;
        logic [7:0]  half;
        logic [3:0]  nbytes;
        logic [3:0]  stall;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{page: 13'h0000, col: 10'h000, half: 8'd0, nbytes: 4'd3, stall: 4'd0},
        '{page: 13'h1FFF, col: 10'h3FF, half: 8'd1, nbytes: 4'd4, stall: 4'd2},
        '{page: 13'h0A55, col: 10'h2AA, half: 8'd2, nbytes: 4'd2, stall: 4'd5},
        '{page: 13'h1234, col: 10'h155, half: 8'd3, nbytes: 4'd1, stall: 4'd1},
        '{page: 13'h0001, col: 10'h200, half: 8'd0, nbytes: 4'd5, stall: 4'd3}
    };

    task automatic wait_valid(output bit ok);
        ok = 0;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (o_valid) begin ok = 1; break; end
        end
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 20000; i++) begin
            if (!o_busy) break;
            @(negedge clk);
        end
    endtask

    task automatic start_pulse(logic [12:0] p, logic [9:0] c, logic [7:0] h);
        wait_idle();
        i_page = p; i_col = c; i_sck_half = h;
        m_page = p; m_col = c;
        i_start = 1'b1;
        @(negedge clk);
        i_start = 1'b0;
        chk(o_cs_n == 1'b0, "R2 cs low after start", o_cs_n, 0);
    endtask

    task automatic run_vector(vec_t v);
        bit ok;
        logic [7:0] held;
        logic s;
        int extra;
        start_pulse(v.page, v.col, v.half);
        i_ready = 1'b0;
        for (int k = 0; k < int'(v.nbytes); k++) begin
            wait_valid(ok);
            chk(ok, "R4 byte arrives", ok, 1);
            if (!ok) return;
            if (k == 0) chk(rise_cnt == 72, "R3 dummy length", rise_cnt, 72);
            held = o_data;
            s    = o_sck;
            if (k == int'(v.nbytes) - 1) begin
                i_stop = 1'b1;
                @(negedge clk);
                i_stop = 1'b0;
            end
            for (int j = 0; j < int'(v.stall); j++) begin
                @(negedge clk);
                chk(o_valid && o_data == held && o_sck == s, "R6 hold while not ready",
                    {o_valid, o_data, o_sck}, {1'b1, held, s});
            end
            chk(held == pat(v.page, v.col, k), "R4 byte value", held, pat(v.page, v.col, k));
            i_ready = 1'b1;
            @(negedge clk);
            i_ready = 1'b0;
            chk(!o_valid, "R6 single pulse", o_valid, 0);
        end
        extra = 0;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (o_valid) extra++;
            if (!o_busy) break;
        end
        chk(extra == 0 && o_cs_n, "R7 stream ends", extra, 0);
        chk(cmd_cap == {8'hE8, 1'b0, v.page, v.col}, "R2 command word",
            cmd_cap, {8'hE8, 1'b0, v.page, v.col});
        chk(int'((t_r6 - t_r5) / 5.0) == 2 * (int'(v.half) + 1), "R5 sck period",
            int'((t_r6 - t_r5) / 5.0), 2 * (int'(v.half) + 1));
    endtask

    initial begin
        bit ok;
        int nval;
        logic [7:0] first;
        logic [12:0] p2;
        logic [9:0]  c2;

        repeat (3) @(negedge clk);
        chk(o_cs_n && !o_sck && !o_valid && !o_busy, "R1 reset state",
            {o_cs_n, o_sck, o_valid, o_busy}, 4'b1000);
        rst_n = 1'b1;
        @(negedge clk);

        foreach (VECS[i]) run_vector(VECS[i]);

        // R7: stop issued during the command phase -> exactly one byte
        start_pulse(13'h0777, 10'h0F0, 8'd1);
        repeat (2) @(negedge clk);
        i_stop = 1'b1; @(negedge clk); i_stop = 1'b0;
        i_ready = 1'b1;
        nval = 0; first = '0;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (o_valid) begin if (nval == 0) first = o_data; nval++; end
            if (!o_busy) break;
        end
        i_ready = 1'b0;
        chk(nval == 1, "R7 early stop byte count", nval, 1);
        chk(first == pat(13'h0777, 10'h0F0, 0), "R7 early stop byte value",
            first, pat(13'h0777, 10'h0F0, 0));

        // R9: start while busy is ignored
        start_pulse(13'h0ABC, 10'h123, 8'd1);
        for (int i = 0; i < 20000 && rise_cnt < 40; i++) @(negedge clk);
        i_page = 13'h1555; i_col = 10'h0AA; i_start = 1'b1;
        @(negedge clk);
        i_start = 1'b0;
        chk(!o_cs_n, "R9 cs stays low", o_cs_n, 0);
        i_ready = 1'b1;
        wait_valid(ok);
        chk(ok && o_data == pat(13'h0ABC, 10'h123, 0), "R9 byte0 unchanged",
            o_data, pat(13'h0ABC, 10'h123, 0));
        wait_valid(ok);
        chk(ok && o_data == pat(13'h0ABC, 10'h123, 1), "R9 byte1 unchanged",
            o_data, pat(13'h0ABC, 10'h123, 1));
        i_stop = 1'b1; @(negedge clk); i_stop = 1'b0;
        chk(cmd_cap == {8'hE8, 1'b0, 13'h0ABC, 10'h123}, "R9 command unchanged",
            cmd_cap, {8'hE8, 1'b0, 13'h0ABC, 10'h123});

        // R8: start held high across the guard interval
        for (int i = 0; i < 20000 && !o_cs_n; i++) @(negedge clk);
        p2 = 13'h0042; c2 = 10'h3C3;
        m_page = p2; m_col = c2; i_page = p2; i_col = c2;
        i_start = 1'b1;
        for (int i = 0; i < 20000 && o_cs_n; i++) @(negedge clk);
        i_start = 1'b0;
        chk(int'((t_csf - t_csr) / 5.0) >= 8, "R8 guard interval",
            int'((t_csf - t_csr) / 5.0), 8);
        i_stop = 1'b1; @(negedge clk); i_stop = 1'b0;
        nval = 0;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (o_valid) nval++;
            if (!o_busy) break;
        end
        i_ready = 1'b0;
        chk(nval == 1 && cmd_cap == {8'hE8, 1'b0, p2, c2}, "R8 restart command",
            cmd_cap, {8'hE8, 1'b0, p2, c2});

        chk(sck_cs_bad == 0, "R1 sck low while deselected", sck_cs_bad, 0);
        chk(o_cs_n && !o_sck && !o_valid && !o_busy, "R1 idle state",
            {o_cs_n, o_sck, o_valid, o_busy}, 4'b1000);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule